// File: doc/BRIEF.md
# Software Interrupt Priority Controller

This block combines one software-owned interrupt request with a set of hardware request lines and decides which of them, if any, is presented to the processor. Software raises its request by writing a one into a request latch. The latch stays set until software writes a zero to it, so a handler that forgets to clear it is entered again as soon as it returns. Each source has its own 3-bit urgency level, written through a small register port. Level 0 is the most urgent. Level 7 disables the source.

An arbiter picks the most urgent pending source and reports it as a one-hot vector together with its level. The winner becomes an interrupt to the processor only if its level is numerically below the processor's current level mask. A separate take strobe marks the cycle in which the processor may accept that interrupt, which is the cycle in which the current instruction finishes.

Source 0 is always the software latch. Hardware line `hwReq[k]` is source k+1. All outputs are combinational from the registered latch, the level registers and the present inputs.

Top module: `swirq_prio_ctrl`

## Requirements
- R1: After reset the software latch is clear and every level register holds 7. With those values `irq` and `intTake` are 0, `irqSrc` is all zero and `irqLevel` is 7, whatever the states of `hwReq` and `cpuMask`.
- R2: A write to address 0 with `wdata[0]`=1 sets the software latch at the clock edge that samples the write. From that edge on, source 0 is pending.
- R3: Only a write to address 0 with `wdata[0]`=0 clears the software latch. Asserting `intTake` does not clear it, so the request stays pending and is raised again until software clears it.
- R4: A write to address 1+k stores `wdata[2:0]` as the level of source k at the sampling edge. A source whose level is 7 never wins, even while it is pending.
- R5: Among the pending sources whose level is below 7, the one with the numerically lowest level wins. When two such sources share a level, the lower source index wins.
- R6: `irq` is 1 exactly when a winner exists and the winner's level is numerically less than `cpuMask`. An equal or higher level gives `irq`=0.
- R7: `irqSrc` is the one-hot winner and `irqLevel` is its level; both are reported even when the mask blocks `irq`. With no winner, `irqSrc` is zero and `irqLevel` is 7.
- R8: `intTake` equals `irq` AND `instrDone` in the same cycle.
- R9: A write to an address above NUM_SRC changes neither the latch nor any level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Write address: 0 = software latch, 1+k = level of source k |
| wdata | input | 3 | Write data: bit 0 for the latch, bits 2:0 for a level |
| hwReq | input | NUM_SRC-1 | Hardware request lines, level sensitive; `hwReq[k]` is source k+1 |
| cpuMask | input | 3 | Processor's current interrupt level mask |
| instrDone | input | 1 | High in the cycle the current instruction completes |
| irq | output | 1 | Interrupt request to the processor |
| irqSrc | output | NUM_SRC | One-hot winning source |
| irqLevel | output | 3 | Level of the winning source, 7 when there is none |
| intTake | output | 1 | Interrupt accepted at this instruction boundary |

## Verification
Two functions can fall in the same cycle: a latch-clearing write and an asserted take, while hardware lines compete with the software source at equal levels. The bench provokes the first case by holding `instrDone` high with the software request active, confirming that the take fires, and then checking that the request still stands cycles later. It then checks, just before the clearing write's edge, that the old request still holds, and just after that edge, that it is gone. Equal-level contention is driven from the vector table, and the bench judges it by the one-hot index it expects from the tie rule.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int LVL_W = 3;
  localparam int SEL_W = 8;
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LVL_OFF = level_t'(7);

  typedef struct packed {
    logic            swWe;
    logic            swVal;
    logic            lvlWe;
    logic [SEL_W-1:0] lvlSel;
    level_t          lvlVal;
  } wr_strobe_t;
endpackage

// File: rtl/swirq_wr_ctrl.sv
module swirq_wr_ctrl
  import swirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  level_t            wdata,
  output wr_strobe_t        wrStb
);
  logic [SEL_W-1:0] addrExt;

  assign addrExt = {{(SEL_W-ADDR_W){1'b0}}, addr};

  always_comb begin
    wrStb.swWe   = wrEn && (addrExt == '0);
    wrStb.swVal  = wdata[0];
    wrStb.lvlWe  = wrEn && (addrExt != '0) && (addrExt <= SEL_W'(NUM_SRC));
    wrStb.lvlSel = addrExt - SEL_W'(1);
    wrStb.lvlVal = wdata;
  end
endmodule

// File: rtl/swirq_arbiter.sv
module swirq_arbiter
  import swirq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pend,
  input  level_t             lvl [NUM_SRC],
  output logic               winValid,
  output logic [NUM_SRC-1:0] winOneHot,
  output level_t             winLevel
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] bestIdx;
  level_t           bestLvl;
  logic             found;

  // Scan upward with a strict compare so the lower index keeps an equal level.
  always_comb begin
    bestLvl = LVL_OFF;
    bestIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (lvl[i] < bestLvl)) begin
        bestLvl = lvl[i];
        bestIdx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  assign winValid  = found;
  assign winLevel  = bestLvl;
  assign winOneHot = found ? (NUM_SRC'(1) << bestIdx) : '0;

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winOneHot));
  p_win_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winLevel != LVL_OFF));
  p_no_pend_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pend == '0) |-> !winValid);
endmodule

// File: rtl/swirq_datapath.sv
module swirq_datapath
  import swirq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wr_strobe_t         wrStb,
  input  logic [NUM_SRC-2:0] hwReq,
  input  level_t             cpuMask,
  input  logic               instrDone,
  output logic               irq,
  output logic [NUM_SRC-1:0] irqSrc,
  output level_t             irqLevel,
  output logic               intTake
);
  logic               swLatch;
  level_t             lvlReg [NUM_SRC];
  logic [NUM_SRC-1:0] pendVec;
  logic               winValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            swLatch <= 1'b0;
    else if (wrStb.swWe)  swLatch <= wrStb.swVal;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lvlReg[k] <= LVL_OFF;
      else if (wrStb.lvlWe && (wrStb.lvlSel == SEL_W'(k)))
        lvlReg[k] <= wrStb.lvlVal;
    end

    p_lvl_write_r4: assert property (@(posedge clk) disable iff (!rstN)
      (wrStb.lvlWe && (wrStb.lvlSel == SEL_W'(k))) |=> (lvlReg[k] == $past(wrStb.lvlVal)));
    p_lvl_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(wrStb.lvlWe && (wrStb.lvlSel == SEL_W'(k))) |=> $stable(lvlReg[k]));
  end

  assign pendVec = {hwReq, swLatch};

  swirq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .pend      (pendVec),
    .lvl       (lvlReg),
    .winValid  (winValid),
    .winOneHot (irqSrc),
    .winLevel  (irqLevel)
  );

  assign irq     = winValid && (irqLevel < cpuMask);
  assign intTake = irq && instrDone;

  p_sw_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.swWe && wrStb.swVal) |=> swLatch);
  p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (swLatch && !(wrStb.swWe && !wrStb.swVal)) |=> swLatch);
  p_sw_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.swWe && !wrStb.swVal) |=> !swLatch);
  p_take_needs_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |-> !intTake);
endmodule

// File: rtl/swirq_prio_ctrl.sv
module swirq_prio_ctrl
  import swirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2:0]         wdata,
  input  logic [NUM_SRC-2:0] hwReq,
  input  logic [2:0]         cpuMask,
  input  logic               instrDone,
  output logic               irq,
  output logic [NUM_SRC-1:0] irqSrc,
  output logic [2:0]         irqLevel,
  output logic               intTake
);
  wr_strobe_t wrStb;

  swirq_wr_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .wdata (wdata),
    .wrStb (wrStb)
  );

  swirq_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .hwReq     (hwReq),
    .cpuMask   (cpuMask),
    .instrDone (instrDone),
    .irq       (irq),
    .irqSrc    (irqSrc),
    .irqLevel  (irqLevel),
    .intTake   (intTake)
  );
endmodule

// File: tb/swirq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module swirq_prio_ctrl_bench;
  localparam int NUM_SRC = 4;
  localparam int ADDR_W  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0]        wdata = '0;
  logic [2:0]        hwReq = '0;
  logic [2:0]        cpuMask = '0;
  logic              instrDone = 1'b0;
  logic              irq;
  logic [3:0]        irqSrc;
  logic [2:0]        irqLevel;
  logic              intTake;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  swirq_prio_ctrl #(.NUM_SRC(NUM_SRC)) u_swirq_prio_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .hwReq(hwReq), .cpuMask(cpuMask), .instrDone(instrDone),
    .irq(irq), .irqSrc(irqSrc), .irqLevel(irqLevel), .intTake(intTake)
  );

  // Entry: levels{s3,s2,s1,s0}, sw, hwReq, mask, done | irq, src, level, take
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {3'd7,3'd7,3'd7,3'd3, 1'b1, 3'b000, 3'd4, 1'b1, 1'b1, 4'b0001, 3'd3, 1'b1},
    {3'd7,3'd7,3'd7,3'd3, 1'b1, 3'b000, 3'd3, 1'b1, 1'b0, 4'b0001, 3'd3, 1'b0},
    {3'd2,3'd5,3'd2,3'd3, 1'b1, 3'b111, 3'd7, 1'b0, 1'b1, 4'b0010, 3'd2, 1'b0},
    {3'd1,3'd5,3'd2,3'd3, 1'b1, 3'b111, 3'd2, 1'b1, 1'b1, 4'b1000, 3'd1, 1'b1},
    {3'd1,3'd5,3'd2,3'd7, 1'b1, 3'b000, 3'd7, 1'b1, 1'b0, 4'b0000, 3'd7, 1'b0},
    {3'd0,3'd0,3'd0,3'd0, 1'b0, 3'b100, 3'd1, 1'b1, 1'b1, 4'b1000, 3'd0, 1'b1},
    {3'd0,3'd0,3'd0,3'd0, 1'b1, 3'b111, 3'd0, 1'b1, 1'b0, 4'b0001, 3'd0, 1'b0},
    {3'd6,3'd4,3'd4,3'd5, 1'b1, 3'b011, 3'd7, 1'b0, 1'b1, 4'b0010, 3'd4, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn  = 1'b1;
    addr  = ADDR_W'(a);
    wdata = 3'(d);
    @(negedge clk);
    wrEn  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state, hardware lines active but all levels disabled
    hwReq = 3'b111; cpuMask = 3'd7; instrDone = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    check("R1 irq", irq, 0);
    check("R1 irqSrc", irqSrc, 0);
    check("R1 irqLevel", irqLevel, 7);
    check("R1 intTake", intTake, 0);
    hwReq = '0; instrDone = 1'b0;

    // R5 R6 R7 R8: vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      for (int k = 0; k < NUM_SRC; k++) wr(1 + k, int'(e[17 + 3*k +: 3]));
      wr(0, int'(e[16]));
      hwReq = e[15:13]; cpuMask = e[12:10]; instrDone = e[9];
      #2;
      check($sformatf("R6 irq vec%0d", v), irq, int'(e[8]));
      check($sformatf("R5 R7 irqSrc vec%0d", v), irqSrc, int'(e[7:4]));
      check($sformatf("R7 irqLevel vec%0d", v), irqLevel, int'(e[3:1]));
      check($sformatf("R8 intTake vec%0d", v), intTake, int'(e[0]));
      hwReq = '0; instrDone = 1'b0;
    end

    // R2 R3: take does not clear the latch; only a zero write does, at the edge
    for (int k = 0; k < NUM_SRC; k++) wr(1 + k, 7);
    wr(1, 2);
    wr(0, 1);
    cpuMask = 3'd7; instrDone = 1'b1;
    #2;
    check("R2 irq after set", irq, 1);
    check("R8 take at boundary", intTake, 1);
    repeat (3) @(negedge clk);
    instrDone = 1'b0;
    #2;
    check("R3 latch held after take", irq, 1);
    check("R3 irqSrc held", irqSrc, 1);
    @(negedge clk);
    wrEn = 1'b1; addr = '0; wdata = 3'b110;   // bit0 = 0 clears
    #5;
    check("R3 clear waits for edge", irq, 1);
    @(negedge clk);
    wrEn = 1'b0;
    #2;
    check("R3 cleared", irq, 0);
    check("R3 irqLevel none", irqLevel, 7);

    // R9: out-of-range addresses ignored (latch clear, source 0 level kept)
    wr(1, 3);
    for (int a = NUM_SRC + 1; a < 8; a++) wr(a, 0);
    wr(0, 1);
    #2;
    check("R9 level kept", irqLevel, 3);
    for (int a = NUM_SRC + 1; a < 8; a++) wr(a, 0);
    #2;
    check("R9 latch kept", irq, 1);

    // R4: disabling a pending source removes it
    wr(1, 7);
    #2;
    check("R4 disabled irq", irq, 0);
    check("R4 disabled src", irqSrc, 0);

    finish_run();
  end
endmodule